// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes an IEEE-754 binary operand and returns the nearest integral value in the same floating-point format. The result stays a floating-point encoding and is not converted to an integer. The rounding direction is fixed at nearest, with ties going to the even integer. A 2-bit size code picks half, single or double precision at run time. The operand and result buses are 64 bits wide. Narrower formats use the low bits, and the unused upper result bits are cleared.

Special operands keep their usual meaning. Zeros and infinities come back with their sign unchanged. A quiet NaN passes through. A signaling NaN is quieted and raises the invalid flag. When the default-NaN control is set, every NaN result is replaced by the format's canonical quiet NaN. A reserved size code, or half precision while half support is switched off, raises the undefined flag and returns an all-zero result. The unit has no inexact flag, because rounding a value never signals inexact. The result and flags are registered, so they appear one clock cycle after the inputs.

Internally, each format lane sorts its operand into one of seven classes: zero, small, near-one, fractional, whole, infinite and NaN. The class selects how the output is built.

Top module: `fprint_unit`

## Requirements
- R1: The size code selects the format: 2'b01 is half (bits 15:0), 2'b10 is single (bits 31:0) and 2'b11 is double (bits 63:0). Operand bits above the selected width are ignored, and result bits above it are zero.
- R2: A finite operand becomes the integral value nearest to it. At an exact tie it becomes the even integer: 2.5 gives 2.0, 3.5 gives 4.0 and -2.5 gives -2.0.
- R3: A finite operand with magnitude at most 0.5 gives a zero with the operand's sign. This covers zeros, subnormals and exactly ±0.5.
- R4: A magnitude strictly between 0.5 and 1.5 gives 1.0 with the operand's sign.
- R5: An operand whose unbiased exponent is at least the fraction width is returned bit for bit unchanged.
- R6: When rounding up carries out of the fraction, the exponent is incremented and the fraction becomes zero. For example, 1.5 gives 2.0 and 1023.5 gives 1024.0.
- R7: An infinity is returned unchanged, with its sign.
- R8: A signaling NaN (top fraction bit 0, fraction non-zero) is returned with its top fraction bit set, and invalid_o is raised. A quiet NaN is returned unchanged. invalid_o is never raised for a non-NaN operand.
- R9: When dflt_nan_i is 1, any NaN operand gives the canonical quiet NaN: sign 0, exponent all ones, only the top fraction bit set. A signaling NaN still raises invalid_o.
- R10: Size code 2'b00 raises undef_o with an all-zero result and invalid_o low, whatever the operand.
- R11: Size code 2'b01 with half_en_i low raises undef_o with an all-zero result.
- R12: Result and flags change one clock cycle after the inputs. While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 64 | Operand; narrower formats in the low bits |
| size_i | input | 2 | Format select code |
| half_en_i | input | 1 | Permits half precision |
| dflt_nan_i | input | 1 | Replace NaN results with the canonical quiet NaN |
| res_o | output | 64 | Registered integral floating-point result |
| undef_o | output | 1 | Registered undefined-operation flag |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
The hardest cases are exact ties and round-up carries in the wide formats. There, a one-bit error in the round, sticky or carry path only shows up for specific bit patterns. Half precision is swept over all 65536 encodings, so every tie, carry, subnormal and NaN in that format is reached. The two wider formats receive pseudo-random operands whose exponents are packed around the region from 0.5 up to the pass-through limit, along with named tie and carry values. Expected results come from a real-number model that rounds to nearest-even and re-encodes the result.

// File: rtl/fprint_pkg.sv
package fprint_pkg;

    // Format selected for the current operation; encoding equals the size code
    typedef enum logic [1:0] {
        FMT_NONE   = 2'b00,
        FMT_HALF   = 2'b01,
        FMT_SINGLE = 2'b10,
        FMT_DOUBLE = 2'b11
    } fmt_e;

    // Operand class inside one lane
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SMALL,
        CLS_NEAR_ONE,
        CLS_FRACT,
        CLS_WHOLE,
        CLS_INF,
        CLS_NAN
    } cls_e;

    localparam int NUM_FMT = 3;

    function automatic int fmt_exp_w(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_frac_w(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fprint_decode.sv
module fprint_decode
    import fprint_pkg::*;
(
    input  logic [1:0] size_i,
    input  logic       half_en_i,
    output fmt_e       fmt_o,
    output logic       undef_o
);

    always_comb begin
        fmt_o   = FMT_NONE;
        undef_o = 1'b0;
        unique case (size_i)
            2'b00: begin
                fmt_o   = FMT_NONE;
                undef_o = 1'b1;
            end
            2'b01: begin
                if (half_en_i) begin
                    fmt_o = FMT_HALF;
                end else begin
                    fmt_o   = FMT_NONE;
                    undef_o = 1'b1;
                end
            end
            2'b10: fmt_o = FMT_SINGLE;
            2'b11: fmt_o = FMT_DOUBLE;
        endcase
    end

endmodule

// File: rtl/fprint_classify.sv
module fprint_classify
    import fprint_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  ex_i,
    input  logic [FRAC_W-1:0] fr_i,
    output cls_e              cls_o
);

    localparam int              BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] E_ONES = '1;
    localparam logic [EXP_W-1:0] E_HALF = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0] E_INT  = EXP_W'(BIAS + FRAC_W);

    always_comb begin
        if (ex_i == E_ONES) begin
            cls_o = (fr_i == '0) ? CLS_INF : CLS_NAN;
        end else if (ex_i == '0 && fr_i == '0) begin
            cls_o = CLS_ZERO;
        end else if (ex_i < E_HALF) begin
            cls_o = CLS_SMALL;
        end else if (ex_i == E_HALF) begin
            cls_o = CLS_NEAR_ONE;
        end else if (ex_i >= E_INT) begin
            cls_o = CLS_WHOLE;
        end else begin
            cls_o = CLS_FRACT;
        end
    end

endmodule

// File: rtl/fprint_round.sv
module fprint_round
    import fprint_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    input  logic                  dflt_nan_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  snan_o
);

    localparam int               W      = 1 + EXP_W + FRAC_W;
    localparam int               MANT_W = FRAC_W + 1;
    localparam int               BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] E_ONES = '1;
    localparam logic [EXP_W-1:0] E_BIAS = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] E_INT  = EXP_W'(BIAS + FRAC_W);

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    cls_e              cls;

    assign sgn = op_i[W-1];
    assign ex  = op_i[W-2:FRAC_W];
    assign fr  = op_i[FRAC_W-1:0];

    fprint_classify #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_classify (
        .ex_i  (ex),
        .fr_i  (fr),
        .cls_o (cls)
    );

    // Fractional path: number of bits below the binary point
    logic [EXP_W-1:0]  shift_amt;
    logic [MANT_W-1:0] mant;
    logic [MANT_W-1:0] unit;
    logic [MANT_W-1:0] half_unit;
    logic [MANT_W-1:0] keep_mask;
    logic [MANT_W-1:0] sticky_mask;
    logic              rnd_bit;
    logic              stk_bit;
    logic              lsb_bit;
    logic              go_up;
    logic [MANT_W:0]   sum;
    logic              carry;
    logic [EXP_W-1:0]  ex_rnd;
    logic [FRAC_W-1:0] fr_rnd;

    always_comb begin
        shift_amt   = E_INT - ex;
        mant        = {1'b1, fr};
        unit        = MANT_W'(1) << shift_amt;
        half_unit   = unit >> 1;
        keep_mask   = ~(unit - MANT_W'(1));
        sticky_mask = half_unit - MANT_W'(1);
        rnd_bit     = |(mant & half_unit);
        stk_bit     = |(mant & sticky_mask);
        lsb_bit     = |(mant & unit);
        go_up       = rnd_bit & (stk_bit | lsb_bit);
        sum         = {1'b0, mant & keep_mask} + {1'b0, unit & {MANT_W{go_up}}};
        carry       = sum[MANT_W];
        ex_rnd      = ex + EXP_W'(carry);
        fr_rnd      = carry ? '0 : sum[FRAC_W-1:0];
    end

    always_comb begin
        res_o  = '0;
        snan_o = 1'b0;
        unique case (cls)
            CLS_ZERO, CLS_SMALL: begin
                res_o = {sgn, {(W-1){1'b0}}};
            end
            CLS_NEAR_ONE: begin
                if (fr == '0) begin
                    res_o = {sgn, {(W-1){1'b0}}};
                end else begin
                    res_o = {sgn, E_BIAS, {FRAC_W{1'b0}}};
                end
            end
            CLS_FRACT: begin
                res_o = {sgn, ex_rnd, fr_rnd};
            end
            CLS_WHOLE, CLS_INF: begin
                res_o = op_i;
            end
            CLS_NAN: begin
                snan_o = ~fr[FRAC_W-1];
                if (dflt_nan_i) begin
                    res_o = {1'b0, E_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
                end else begin
                    res_o = {sgn, E_ONES, 1'b1, fr[FRAC_W-2:0]};
                end
            end
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/fprint_unit.sv
module fprint_unit
    import fprint_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] op_i,
    input  logic [1:0]        size_i,
    input  logic              half_en_i,
    input  logic              dflt_nan_i,
    output logic [DATA_W-1:0] res_o,
    output logic              undef_o,
    output logic              invalid_o
);

    fmt_e              fmt;
    logic              undef_nxt;
    logic [DATA_W-1:0] lane_res  [NUM_FMT];
    logic              lane_snan [NUM_FMT];
    logic [DATA_W-1:0] res_nxt;
    logic              inv_nxt;

    fprint_decode u_decode (
        .size_i    (size_i),
        .half_en_i (half_en_i),
        .fmt_o     (fmt),
        .undef_o   (undef_nxt)
    );

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
        localparam int EW = fmt_exp_w(g);
        localparam int FW = fmt_frac_w(g);
        localparam int LW = 1 + EW + FW;

        logic [LW-1:0] lane_out;

        fprint_round #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_round (
            .op_i       (op_i[LW-1:0]),
            .dflt_nan_i (dflt_nan_i),
            .res_o      (lane_out),
            .snan_o     (lane_snan[g])
        );

        assign lane_res[g] = DATA_W'(lane_out);
    end

    always_comb begin
        res_nxt = '0;
        inv_nxt = 1'b0;
        unique case (fmt)
            FMT_NONE: begin
                res_nxt = '0;
                inv_nxt = 1'b0;
            end
            FMT_HALF: begin
                res_nxt = lane_res[0];
                inv_nxt = lane_snan[0];
            end
            FMT_SINGLE: begin
                res_nxt = lane_res[1];
                inv_nxt = lane_snan[1];
            end
            FMT_DOUBLE: begin
                res_nxt = lane_res[2];
                inv_nxt = lane_snan[2];
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_o     <= '0;
            undef_o   <= 1'b0;
            invalid_o <= 1'b0;
        end else begin
            res_o     <= res_nxt;
            undef_o   <= undef_nxt;
            invalid_o <= inv_nxt;
        end
    end

endmodule

// File: rtl/fprint_unit_chk.sv
module fprint_unit_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [63:0] op_i,
    input logic [1:0]  size_i,
    input logic        half_en_i,
    input logic        dflt_nan_i,
    input logic [63:0] res_o,
    input logic        undef_o,
    input logic        invalid_o
);

    // R10
    a_r10_reserved_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b00 |=> undef_o && res_o == '0 && !invalid_o);

    // R11
    a_r11_half_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b01 && !half_en_i |=> undef_o && res_o == '0);

    // R1
    a_r1_half_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b01 && half_en_i |=> !undef_o && res_o[63:16] == '0);

    a_r1_single_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b10 |=> !undef_o && res_o[63:32] == '0);

    // R7
    a_r7_double_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b11 && op_i[62:0] == 63'h7FF0_0000_0000_0000 |=> res_o == $past(op_i));

    // R5
    a_r5_double_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b11 && op_i[62:52] >= 11'd1075 && op_i[62:52] != 11'h7FF
        |=> res_o == $past(op_i));

    // R3
    a_r3_double_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b11 && op_i[62:52] < 11'd1022 |=> res_o == {$past(op_i[63]), 63'b0});

    // R8
    a_r8_no_invalid_nonnan: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b11 && op_i[62:52] != 11'h7FF |=> !invalid_o);

    // R9
    a_r9_double_default_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_i == 2'b11 && dflt_nan_i && op_i[62:52] == 11'h7FF && op_i[51:0] != '0
        |=> res_o == 64'h7FF8_0000_0000_0000);

endmodule

bind fprint_unit fprint_unit_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op_i),
    .size_i     (size_i),
    .half_en_i  (half_en_i),
    .dflt_nan_i (dflt_nan_i),
    .res_o      (res_o),
    .undef_o    (undef_o),
    .invalid_o  (invalid_o)
);

// File: tb/test_fprint_unit.sv
`timescale 1ns/1ps
module test_fprint_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] op;
    logic [1:0]  size;
    logic        hen;
    logic        dn;
    logic [63:0] res;
    logic        undef;
    logic        inv;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    fprint_unit i_fprint_unit (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .op_i       (op),
        .size_i     (size),
        .half_en_i  (hen),
        .dflt_nan_i (dn),
        .res_o      (res),
        .undef_o    (undef),
        .invalid_o  (inv)
    );

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // Reference: {undef, invalid, result} from real arithmetic
    function automatic logic [65:0] model(input logic [63:0] raw, input int E, input int F,
                                          input bit dnm);
        logic [63:0] opm, fmask, f, qb, r;
        int          w, bias, e, ex;
        logic        s;
        real         mag, fl, p, fr;
        bit          iv = 1'b0;
        w     = 1 + E + F;
        opm   = (w == 64) ? raw : (raw & ((64'd1 << w) - 64'd1));
        bias  = (1 << (E - 1)) - 1;
        fmask = (64'd1 << F) - 64'd1;
        s     = opm[E+F];
        e     = int'((opm >> F) & ((64'd1 << E) - 64'd1));
        f     = opm & fmask;
        qb    = 64'd1 << (F - 1);
        if (e == (1 << E) - 1) begin
            if (f == 64'd0) begin
                r = opm;
            end else begin
                iv = ((f & qb) == 64'd0);
                r  = dnm ? ((64'((1 << E) - 1) << F) | qb) : (opm | qb);
            end
        end else begin
            if (e == 0) mag = real'(f) * (2.0 ** (1 - bias - F));
            else        mag = (1.0 + real'(f) / (2.0 ** F)) * (2.0 ** (e - bias));
            fl = $floor(mag);
            if ((mag - fl > 0.5) || (mag - fl == 0.5 && $floor(fl / 2.0) * 2.0 != fl))
                fl = fl + 1.0;
            if (fl == 0.0) begin
                r = 64'(s) << (E + F);
            end else begin
                p  = 1.0;
                ex = 0;
                while (p * 2.0 <= fl) begin
                    p  = p * 2.0;
                    ex = ex + 1;
                end
                fr = (fl / p - 1.0) * (2.0 ** F);
                r  = (64'(s) << (E + F)) | (64'(ex + bias) << F) | (64'(longint'(fr)) & fmask);
            end
        end
        return {1'b0, iv, r};
    endfunction

    task automatic apply(input logic [63:0] o, input logic [1:0] sz, input bit h, input bit d);
        @(negedge clk);
        op   = o;
        size = sz;
        hen  = h;
        dn   = d;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic dcheck(input string tag, input logic [63:0] o, input logic [63:0] r, input bit iv);
        apply(o, 2'b11, 1'b1, 1'b0);
        check(tag, {undef, inv, res}, {1'b0, iv, r});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op    = 64'h7FF0_0000_0000_0001;
        size  = 2'b11;
        hen   = 1'b1;
        dn    = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R12 reset state", {undef, inv, res}, 66'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: latency of one cycle
        apply(64'h4004_0000_0000_0000, 2'b11, 1'b1, 1'b0);
        check("R12 one-cycle result", {undef, inv, res}, {2'b00, 64'h4000_0000_0000_0000});

        // R2 ties to even
        dcheck("R2 2.5", 64'h4004_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0);
        dcheck("R2 3.5", 64'h400C_0000_0000_0000, 64'h4010_0000_0000_0000, 1'b0);
        dcheck("R2 -2.5", 64'hC004_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b0);
        // R3 small magnitudes
        dcheck("R3 0.5", 64'h3FE0_0000_0000_0000, 64'h0, 1'b0);
        dcheck("R3 -0.5", 64'hBFE0_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        dcheck("R3 -0.0", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        dcheck("R3 subnormal", 64'h0000_0000_0000_0001, 64'h0, 1'b0);
        // R4 near one
        dcheck("R4 0.75", 64'h3FE8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0);
        dcheck("R4 -1.25", 64'hBFF4_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1'b0);
        // R6 carry into exponent
        dcheck("R6 1.5", 64'h3FF8_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0);
        dcheck("R6 1023.5", 64'h408F_FC00_0000_0000, 64'h4090_0000_0000_0000, 1'b0);
        // R5 pass-through
        dcheck("R5 2^53+2", 64'h4340_0000_0000_0001, 64'h4340_0000_0000_0001, 1'b0);
        // R7 infinity
        dcheck("R7 -inf", 64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b0);
        // R8 NaNs
        dcheck("R8 sNaN", 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1'b1);
        dcheck("R8 qNaN", 64'h7FF8_0000_0000_0002, 64'h7FF8_0000_0000_0002, 1'b0);
        // R9 default NaN
        apply(64'hFFF0_0000_0000_0005, 2'b11, 1'b1, 1'b1);
        check("R9 default NaN from sNaN", {undef, inv, res}, {2'b01, 64'h7FF8_0000_0000_0000});
        apply(64'hFFF8_0000_0000_0001, 2'b11, 1'b1, 1'b1);
        check("R9 default NaN from qNaN", {undef, inv, res}, {2'b00, 64'h7FF8_0000_0000_0000});
        // R10 reserved size
        apply(64'h7FF0_0000_0000_0001, 2'b00, 1'b1, 1'b0);
        check("R10 size 00", {undef, inv, res}, {2'b10, 64'h0});
        apply(64'h4004_0000_0000_0000, 2'b00, 1'b1, 1'b0);
        check("R10 size 00 finite", {undef, inv, res}, {2'b10, 64'h0});
        // R11 half disabled
        apply(64'h0000_0000_0000_4100, 2'b01, 1'b0, 1'b0);
        check("R11 half disabled", {undef, inv, res}, {2'b10, 64'h0});
        // R1 narrow formats with junk upper bits
        apply(64'hDEAD_BEEF_CAFE_4100, 2'b01, 1'b1, 1'b0);
        check("R1 half 2.5", {undef, inv, res}, {2'b00, 64'h0000_0000_0000_4000});
        apply(64'hDEAD_BEEF_4020_0000, 2'b10, 1'b1, 1'b0);
        check("R1 single 2.5", {undef, inv, res}, {2'b00, 64'h0000_0000_4000_0000});

        // R2/R1: every half encoding
        for (int h = 0; h < 65536; h++) begin
            logic [63:0] o = {rs[63:16], 16'(h)};
            rs = next_rand(rs);
            apply(o, 2'b01, 1'b1, 1'b0);
            check("R2 half sweep", {undef, inv, res}, model(o, 5, 10, 1'b0));
        end
        // R9: every half NaN in default-NaN mode
        for (int h = 0; h < 65536; h++) begin
            if (((h >> 10) & 31) == 31 && (h & 1023) != 0) begin
                apply(64'(h), 2'b01, 1'b1, 1'b1);
                check("R9 half NaN sweep", {undef, inv, res}, model(64'(h), 5, 10, 1'b1));
            end
        end
        // R2/R6: single precision, exponents near the interesting range
        for (int i = 0; i < 16000; i++) begin
            logic [63:0] o;
            rs = next_rand(rs);
            if (i % 8 == 0) o = rs;
            else o = {rs[63:32], rs[31], 8'(124 + int'(rs[40:33] % 30)), rs[22:0]};
            apply(o, 2'b10, 1'b1, 1'b0);
            check("R2 single sweep", {undef, inv, res}, model(o, 8, 23, 1'b0));
        end
        // R2/R5/R6: double precision
        for (int i = 0; i < 16000; i++) begin
            logic [63:0] o;
            rs = next_rand(rs);
            if (i % 8 == 0) o = rs;
            else o = {rs[63], 11'(1020 + int'(rs[62:52] % 58)), rs[51:0]};
            apply(o, 2'b11, 1'b1, 1'b0);
            check("R2 double sweep", {undef, inv, res}, model(o, 11, 52, 1'b0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule